// File: doc/BRIEF.md
# Continuous Pulse Pattern Transmitter

This block plays a short list of (level, duration) pairs from a small local item memory and drives them onto one output pin. Software loads the items through an address/data/write-enable port. It then chooses a tick divider and a loop mode and raises a start control. Timing comes from an external tick enable. A programmable divider thins the tick into the divided tick that advances playback.

Each 32-bit item packs two halves. Each half holds an output level and a 15-bit duration, and a zero duration ends the pattern. In one-shot mode the block stops at that end marker. In loop mode it goes straight back to the first item. A channel enable freezes all playback activity, and a pointer-reset control rewinds to the first item. One item that drives high for a single tick and then ends at level low, looped, gives a square wave at half the divided tick rate.

Top module: `pulse_pattern_tx`

## Requirements
- R1: An item word carries its first half in bits [15:0] and its second half in bits [31:16]. Within a half, bit 15 is the output level and bits [14:0] are the duration. The first half plays before the second, and items play in ascending address order.
- R2: A half with a non-zero duration D drives its level on `pulse_o` for exactly D divided ticks.
- R3: A half with duration 0 is the end marker. It drives its own level for exactly one divided tick.
- R4: When the end marker's tick expires with `cont_i`=1, playback resumes at item 0, first half, with no extra tick. With `cont_i`=0 the block stops, and `pulse_o` stays 0 while `start_i` remains 1, until `start_i` is cleared and set again.
- R5: A divided tick occurs on every `div_i`-th input tick, and `div_i`=0 means 256. The divider count restarts from zero whenever playback is not running.
- R6: With `chan_en_i`=1, `start_i`=1 begins playback at the current item position. Clearing `start_i` stops playback at the next clock, drives `pulse_o` to 0, and keeps the position so that a later start resumes there with that half's full duration.
- R7: Pulsing `ptr_rst_i` returns the position to item 0, first half.
- R8: `pulse_o` is 0 whenever playback is not running, including after reset.
- R9: While `chan_en_i`=0, ticks are ignored: the divider and the position are frozen, and playback does not begin.
- R10: Item 0 = {second half: level 0, duration 0; first half: level 1, duration 1} in loop mode gives a square wave with a period of two divided ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base tick enable, one clock wide |
| chan_en_i | input | 1 | Channel enable; 0 freezes playback |
| div_i | input | 8 | Tick divider count (0 = 256) |
| start_i | input | 1 | Run control, level sensitive |
| cont_i | input | 1 | 1 = loop at end marker, 0 = one-shot |
| ptr_rst_i | input | 1 | Rewind item position to item 0 |
| mem_we_i | input | 1 | Item memory write enable |
| mem_addr_i | input | 6 | Item memory write address |
| mem_wdata_i | input | 32 | Item word to write |
| pulse_o | output | 1 | Pattern output |

## Verification
The bench targets the end marker. A design that skips the marker's tick outputs a constant high instead of the square wave. A design that fails to loop, or that restarts after a one-shot end, leaves the wrong level after the pattern finishes. Divided-tick counts are checked at divider values above one, which exposes a divider that is off by one or does not clear between runs. Directed tests cover the following cases:
- ticks arriving while the channel is disabled, which a design that fails to freeze would let advance the pattern;
- a halt followed by a restart, where a design that loses its position would replay the first half;
- a pointer rewind, which must bring the first half back.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam int unsigned DUR_W  = 15;
  localparam int unsigned HALF_W = DUR_W + 1;
  localparam int unsigned ITEM_W = 2 * HALF_W;

  typedef struct packed {
    logic             lvl;
    logic [DUR_W-1:0] dur;
  } half_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ppt_item_mem.sv
module ppt_item_mem
  import ppt_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [ITEM_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  input  logic              hsel_i,
  output half_t             half_o
);
  logic [ITEM_W-1:0] mem_q [DEPTH];
  logic [ITEM_W-1:0] word;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign word = mem_q[raddr_i];

  // second half sits in the upper bits
  always_comb begin
    if (hsel_i) half_o = half_t'(word[ITEM_W-1:HALF_W]);
    else        half_o = half_t'(word[HALF_W-1:0]);
  end
endmodule

// File: rtl/ppt_tick_div.sv
module ppt_tick_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             dtick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_inc;
  logic             hit;

  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = (cnt_inc == div_i);   // div 0 wraps to full range
  assign dtick_o = tick_i & en_i & ~clr_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (tick_i && en_i)   cnt_q <= hit ? '0 : cnt_inc;
  end

  AST_DIV_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dtick_o |=> (cnt_q == '0)); // R5
  AST_DIV_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/ppt_sequencer.sv
module ppt_sequencer
  import ppt_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          cont_i,
  input  logic          ptr_rst_i,
  input  logic          dtick_i,
  input  half_t         half_i,
  output logic [AW-1:0] ptr_o,
  output logic          hsel_o,
  output logic          run_o
);
  seq_state_e       state_q;
  logic [AW-1:0]    ptr_q;
  logic             hsel_q;
  logic [DUR_W-1:0] rem_q, eff_dur;
  logic             is_end, last;

  assign is_end  = (half_i.dur == '0);
  assign eff_dur = is_end ? DUR_W'(1) : half_i.dur;   // end marker lasts one tick
  assign last    = (rem_q == eff_dur - DUR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      hsel_q  <= 1'b0;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i && en_i) state_q <= ST_RUN;
        ST_RUN: begin
          if (!start_i) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
          end else if (dtick_i) begin
            if (last) begin
              rem_q <= '0;
              if (is_end) begin
                if (cont_i) begin
                  ptr_q  <= '0;
                  hsel_q <= 1'b0;
                end else begin
                  state_q <= ST_DONE;
                end
              end else begin
                hsel_q <= ~hsel_q;
                if (hsel_q) ptr_q <= ptr_q + 1'b1;
              end
            end else begin
              rem_q <= rem_q + 1'b1;
            end
          end
        end
        ST_DONE: if (!start_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
      if (ptr_rst_i) begin
        ptr_q  <= '0;
        hsel_q <= 1'b0;
        rem_q  <= '0;
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign hsel_o = hsel_q;
  assign run_o  = (state_q == ST_RUN);

  AST_PTR_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst_i |=> (ptr_q == '0 && !hsel_q)); // R7
  AST_POS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ptr_rst_i) |=> ($stable(ptr_q) && $stable(hsel_q))); // R9
  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && start_i) |=> (state_q == ST_DONE)); // R4
  AST_NO_START_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !en_i) |=> (state_q == ST_IDLE)); // R9
endmodule

// File: rtl/pulse_pattern_tx.sv
module pulse_pattern_tx
  import ppt_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DIV_W = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              chan_en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic              ptr_rst_i,
  input  logic              mem_we_i,
  input  logic [AW-1:0]     mem_addr_i,
  input  logic [ITEM_W-1:0] mem_wdata_i,
  output logic              pulse_o
);
  logic          dtick, run, hsel;
  logic [AW-1:0] ptr;
  half_t         cur;

  ppt_item_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we_i),
    .waddr_i (mem_addr_i),
    .wdata_i (mem_wdata_i),
    .raddr_i (ptr),
    .hsel_i  (hsel),
    .half_o  (cur)
  );

  ppt_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .en_i    (chan_en_i),
    .clr_i   (~run),
    .div_i   (div_i),
    .dtick_o (dtick)
  );

  ppt_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (chan_en_i),
    .start_i   (start_i),
    .cont_i    (cont_i),
    .ptr_rst_i (ptr_rst_i),
    .dtick_i   (dtick),
    .half_i    (cur),
    .ptr_o     (ptr),
    .hsel_o    (hsel),
    .run_o     (run)
  );

  assign pulse_o = run & cur.lvl;

  AST_HALT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !pulse_o); // R6
endmodule

// File: tb/sim_pulse_pattern_tx.sv
module sim_pulse_pattern_tx;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 6;
  localparam int  NTICK = 16;

  // {cont, div, word1, word0}; half = {lvl, dur[14:0]}, first half in [15:0]
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b1, 8'd1, 32'h0, {1'b0, 15'd0, 1'b1, 15'd1}},
    {1'b1, 8'd2, 32'h0, {1'b0, 15'd0, 1'b1, 15'd1}},
    {1'b0, 8'd1, {1'b0, 15'd0, 1'b1, 15'd1}, {1'b0, 15'd3, 1'b1, 15'd2}},
    {1'b1, 8'd1, {1'b0, 15'd0, 1'b1, 15'd1}, {1'b0, 15'd3, 1'b1, 15'd2}},
    {1'b1, 8'd3, 32'h0, {1'b1, 15'd0, 1'b0, 15'd2}},
    {1'b0, 8'd1, 32'h0, {1'b0, 15'd5, 1'b1, 15'd0}}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, chan_en = 1'b1, start = 1'b0, cont = 1'b0, ptr_rst = 1'b0;
  logic [7:0]  div = 8'd1;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        pulse;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_pattern_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .chan_en_i(chan_en), .div_i(div),
    .start_i(start), .cont_i(cont), .ptr_rst_i(ptr_rst), .mem_we_i(we),
    .mem_addr_i(addr), .mem_wdata_i(wdata), .pulse_o(pulse)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pulse_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  // level expected after m divided ticks, from the requirements
  function automatic logic model(input logic [31:0] w0, input logic [31:0] w1,
                                 input logic c, input int m_in);
    int m = m_in;
    int idx = 0;
    for (int g = 0; g < 1000; g++) begin
      logic [31:0] w = (idx / 2 == 0) ? w0 : ((idx / 2 == 1) ? w1 : 32'h0);
      logic [15:0] h = idx[0] ? w[31:16] : w[15:0];
      int eff = (h[14:0] == 0) ? 1 : int'(h[14:0]);
      if (m < eff) return h[15];
      m -= eff;
      if (h[14:0] == 0) begin
        if (c) idx = 0;
        else return 1'b0;
      end else idx++;
    end
    return 1'b0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    step();
    chk("R8 reset", pulse, 1'b0);
    step();
    rst_n = 1'b1;
    step();
    chk("R8 idle after reset", pulse, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] w0 = VEC[v][31:0];
      logic [31:0] w1 = VEC[v][63:32];
      string tag;
      case (v)
        0: tag = "R10 square";
        1: tag = "R5 divider";
        2: tag = "R1 R2 one-shot";
        3: tag = "R4 loop";
        4: tag = "R3 end level";
        default: tag = "R3 R4 end first";
      endcase
      start = 1'b0; step();
      ptr_rst = 1'b1; step(); ptr_rst = 1'b0;
      wr(6'd0, w0);
      wr(6'd1, w1);
      div = VEC[v][71:64];
      cont = VEC[v][72];
      start = 1'b1;
      step();
      chk(tag, pulse, model(w0, w1, cont, 0));
      for (int n = 1; n <= NTICK; n++) begin
        do_tick();
        chk(tag, pulse, model(w0, w1, cont, n / int'(div)));
      end
    end

    // directed: no start while disabled, freeze, halt/resume, rewind
    start = 1'b0; div = 8'd1; cont = 1'b0; step();
    ptr_rst = 1'b1; step(); ptr_rst = 1'b0;
    wr(6'd0, {1'b0, 15'd3, 1'b1, 15'd2});
    wr(6'd1, {1'b0, 15'd0, 1'b1, 15'd1});
    chan_en = 1'b0; start = 1'b1; step();
    repeat (3) do_tick();
    chk("R9 no start while disabled", pulse, 1'b0);
    chan_en = 1'b1; step();
    chk("R6 start", pulse, 1'b1);
    do_tick();
    chk("R2 first half mid", pulse, 1'b1);
    chan_en = 1'b0;
    repeat (5) do_tick();
    chk("R9 frozen", pulse, 1'b1);
    chan_en = 1'b1;
    do_tick();
    chk("R2 first half done", pulse, 1'b0);
    start = 1'b0; step();
    chk("R6 halt", pulse, 1'b0);
    start = 1'b1; step();
    chk("R6 resume position", pulse, 1'b0);
    repeat (3) do_tick();
    chk("R6 resume full duration", pulse, 1'b1);
    do_tick();
    chk("R3 end marker", pulse, 1'b0);
    start = 1'b0; step();
    ptr_rst = 1'b1; step(); ptr_rst = 1'b0;
    start = 1'b1; step();
    chk("R7 rewind", pulse, 1'b1);
    start = 1'b0; step();
    chk("R8 stopped", pulse, 1'b0);
    report();
  end
endmodule